// File: doc/BRIEF.md
# Prescaled Reload Down-Counter Timer

This block is a 16-bit timer that counts down from a value held in a reload register. Each count step comes from a prescaler that divides the machine clock by 2, 8 or 32. The division is picked by a two-bit field in a 12-bit control register. Software starts the timer by writing the count-enable and trigger bits together, which copies the reload value into the counter.

Underflow means the counter steps from 0x0000 to 0xFFFF. On each underflow the block sets a sticky flag. It then either reloads and keeps counting, or stops with the counter at 0xFFFF, as chosen by a mode bit. An interrupt request is raised while the flag is set and interrupts are enabled.

All registers sit on a single-cycle register port with a combinational read path. Word address 0 is the control register. Address 1 is the reload register. Address 2 is the read-only live count.

Top module: `prescaled_reload_timer`

## Requirements
- R1: After reset the control register, the reload register and the count all read 0x0000, and `irq` is low.
- R2: Control bits [11:10] choose the tick period: 00 gives a tick every 2 clocks, 01 every 8, and 10 every 32. With 11 the counter never moves. The prescaler restarts from zero on every trigger.
- R3: A control write with bit 1 (count enable) and bit 0 (trigger) both 1 loads the reload value into the counter and starts counting. A trigger written with bit 1 at 0 leaves the count unchanged. Bit 0 always reads back as 0.
- R4: While running, each tick decrements the count by one, and a tick at 0x0000 is an underflow.
- R5: With bit 4 (reload mode) set, an underflow loads the reload register into the counter and counting goes on.
- R6: With bit 4 clear, an underflow leaves the count at 0xFFFF and the counter stays stopped until the next trigger.
- R7: Bit 2 (underflow flag) is set by every underflow and is cleared only by writing 0 to it. Writing 1 to it leaves it unchanged.
- R8: `irq` is high exactly when bit 2 and bit 3 (interrupt enable) are both 1.
- R9: Writes to bits [11:3] take effect only while count enable is currently 0, and are ignored otherwise. Bits 2, 1 and 0 are written in every access.
- R10: Clearing count enable freezes the count at its current value, which stays readable at address 2.
- R11: When an underflow and a write of 0 to the flag fall in the same cycle, the flag ends up set.
- R12: The reload register can be written at any time, and it reads back the value written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Machine clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 2 | Word address: 0 control, 1 reload, 2 count |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational, zero when not selected |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can land on the same clock edge. The first pair is an underflow setting the flag while software writes 0 to clear it. The bench provokes this by triggering a one-shot count with reload value 1 at divide-by-2, then timing a flag-clear write so that it lands on the fourth edge after the trigger, which is the underflow edge. It judges the outcome by reading the flag back as set. The second pair is a trigger landing on a tick edge. There the load must win over the decrement, and the checker watches this on every trigger.

// File: rtl/prt_pkg.sv
package prt_pkg;

  localparam int CSR_W = 12;

  typedef struct packed {
    logic [1:0] csel;
    logic [2:0] mode;
    logic       oen;
    logic       olvl;
    logic       rld;
    logic       ien;
    logic       uf;
    logic       cnte;
    logic       trg;
  } csr_t;

  typedef enum logic [1:0] {
    ADDR_CSR = 2'd0,
    ADDR_RLD = 2'd1,
    ADDR_CNT = 2'd2
  } reg_addr_e;

  // Code 11 selects no tick source.
  function automatic logic csel_valid(input logic [1:0] c);
    return c != 2'b11;
  endfunction

  // Tick period is 2 * 4^c clocks; returns period - 1.
  function automatic logic [5:0] tick_limit(input logic [1:0] c);
    logic [5:0] period;
    period = 6'd2 << {c, 1'b0};
    return period - 6'd1;
  endfunction

  // The flag is set by an event, and only a written 0 clears it.
  function automatic logic flag_next(input logic cur, input logic set_ev,
                                     input logic wr, input logic wbit);
    return set_ev | (cur & ~(wr & ~wbit));
  endfunction

endpackage

// File: rtl/prt_prescaler.sv
module prt_prescaler
  import prt_pkg::*;
#(
  parameter int PRE_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       restart,
  input  logic [1:0] csel,
  output logic       tick
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] limit;

  assign limit = PRE_W'(tick_limit(csel));
  assign tick  = active && csel_valid(csel) && (pre_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (!active || restart || tick) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

endmodule

// File: rtl/prt_counter.sv
module prt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_ld,
  input  logic             tick,
  input  logic             rld,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             uflow
);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  // A trigger takes priority over a tick in the same cycle.
  assign uflow   = tick && !trig_ld && (cnt_q == '0);
  assign count   = cnt_q;
  assign running = run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (trig_ld) begin
      cnt_q <= reload;
      run_q <= 1'b1;
    end else if (uflow) begin
      cnt_q <= rld ? reload : '1;
      run_q <= rld;
    end else if (tick) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/prt_regs.sv
module prt_regs
  import prt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              uflow,
  input  logic [CNT_W-1:0]  count,
  output csr_t              csr,
  output logic [CNT_W-1:0]  reload,
  output logic              trig_ld
);

  csr_t             csr_q;
  csr_t             wcsr;
  logic [CNT_W-1:0] rld_q;
  logic             wr_csr;
  logic             wr_rld;

  assign wr_csr  = bus_sel && bus_wr && (bus_addr == ADDR_W'(ADDR_CSR));
  assign wr_rld  = bus_sel && bus_wr && (bus_addr == ADDR_W'(ADDR_RLD));
  assign wcsr    = csr_t'(bus_wdata[CSR_W-1:0]);
  assign trig_ld = wr_csr && wcsr.cnte && wcsr.trg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_q <= '0;
    end else begin
      if (wr_csr) begin
        csr_q.cnte <= wcsr.cnte;
        if (!csr_q.cnte) begin
          csr_q.csel <= wcsr.csel;
          csr_q.mode <= wcsr.mode;
          csr_q.oen  <= wcsr.oen;
          csr_q.olvl <= wcsr.olvl;
          csr_q.rld  <= wcsr.rld;
          csr_q.ien  <= wcsr.ien;
        end
      end
      csr_q.uf  <= flag_next(csr_q.uf, uflow, wr_csr, wcsr.uf);
      csr_q.trg <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld_q <= '0;
    end else if (wr_rld) begin
      rld_q <= bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      unique case (bus_addr)
        ADDR_W'(ADDR_CSR): bus_rdata = DATA_W'(csr_q);
        ADDR_W'(ADDR_RLD): bus_rdata = DATA_W'(rld_q);
        ADDR_W'(ADDR_CNT): bus_rdata = DATA_W'(count);
        default:           bus_rdata = '0;
      endcase
    end
  end

  assign csr    = csr_q;
  assign reload = rld_q;

endmodule

// File: rtl/prescaled_reload_timer.sv
module prescaled_reload_timer
  import prt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16,
  parameter int PRE_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  csr_t             csr;
  logic [CNT_W-1:0] reload_val;
  logic [CNT_W-1:0] count;
  logic             trig_ld;
  logic             tick;
  logic             uflow;
  logic             run;
  logic             active;

  // Named event and state wires for the checker.
  logic             csr_cnte;
  logic             csr_rld;
  logic             csr_uf;
  logic             csr_ien;
  logic [1:0]       csr_csel;

  assign csr_cnte = csr.cnte;
  assign csr_rld  = csr.rld;
  assign csr_uf   = csr.uf;
  assign csr_ien  = csr.ien;
  assign csr_csel = csr.csel;
  assign active   = csr_cnte && run;
  assign irq      = csr_uf && csr_ien;

  prt_regs #(
    .CNT_W (CNT_W),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .uflow    (uflow),
    .count    (count),
    .csr      (csr),
    .reload   (reload_val),
    .trig_ld  (trig_ld)
  );

  prt_prescaler #(
    .PRE_W(PRE_W)
  ) u_prescaler (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (active),
    .restart(trig_ld),
    .csel   (csr_csel),
    .tick   (tick)
  );

  prt_counter #(
    .CNT_W(CNT_W)
  ) u_counter (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig_ld(trig_ld),
    .tick   (tick),
    .rld    (csr_rld),
    .reload (reload_val),
    .count  (count),
    .running(run),
    .uflow  (uflow)
  );

endmodule

// File: rtl/prt_checker.sv
module prt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             uflow,
  input logic             trig_ld,
  input logic             run,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] reload_val,
  input logic             csr_cnte,
  input logic             csr_rld,
  input logic             csr_uf,
  input logic             csr_ien,
  input logic [1:0]       csr_csel,
  input logic             irq
);

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n) tick |=> !tick); // R2
  AST_TRIG_LOAD: assert property (@(posedge clk) disable iff (!rst_n) trig_ld |=> (run && count == $past(reload_val))); // R3
  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n) (tick && !uflow && !trig_ld) |=> count == CNT_W'($past(count) - 1'b1)); // R4
  AST_RELOAD_ON_UF: assert property (@(posedge clk) disable iff (!rst_n) (uflow && csr_rld) |=> count == $past(reload_val)); // R5
  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n) (uflow && !csr_rld) |=> (!run && count == '1)); // R6
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n) uflow |=> csr_uf); // R7
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (csr_ien && csr_uf)); // R8
  AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n) csr_cnte |=> ($stable(csr_csel) && $stable(csr_rld) && $stable(csr_ien))); // R9
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!csr_cnte && !trig_ld) |=> $stable(count)); // R10

endmodule

bind prescaled_reload_timer prt_checker #(.CNT_W(CNT_W)) u_prt_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .uflow     (uflow),
  .trig_ld   (trig_ld),
  .run       (run),
  .count     (count),
  .reload_val(reload_val),
  .csr_cnte  (csr_cnte),
  .csr_rld   (csr_rld),
  .csr_uf    (csr_uf),
  .csr_ien   (csr_ien),
  .csr_csel  (csr_csel),
  .irq       (irq)
);

// File: tb/test_prescaled_reload_timer.sv
module test_prescaled_reload_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail = 0;

  localparam logic [1:0] A_CSR = 2'd0;
  localparam logic [1:0] A_RLD = 2'd1;
  localparam logic [1:0] A_CNT = 2'd2;

  always #4 clk = ~clk;

  prescaled_reload_timer i_prescaled_reload_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq      (irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a; bus_sel = 1'b1;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    bus_read(A_CSR, d); check("R1 ctrl", d, 16'h0000);
    bus_read(A_RLD, d); check("R1 reload", d, 16'h0000);
    bus_read(A_CNT, d); check("R1 count", d, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'h0000);
  endtask

  task automatic t_oneshot();
    logic [15:0] d;
    bus_write(A_RLD, 16'd5);
    bus_write(A_CSR, 16'h0003);
    bus_read(A_CNT, d); check("R3 load on trigger", d, 16'd5);
    bus_read(A_CSR, d); check("R3 trigger reads 0", d, 16'h0002);
    wait_cyc(4);
    bus_read(A_CNT, d); check("R4 R2 two decrements at div2", d, 16'd3);
    wait_cyc(8);
    bus_read(A_CNT, d); check("R4 underflow to FFFF", d, 16'hFFFF);
    bus_read(A_CSR, d); check("R7 flag set", d, 16'h0006);
    check("R8 irq low without enable", {15'd0, irq}, 16'h0000);
    wait_cyc(20);
    bus_read(A_CNT, d); check("R6 stays stopped", d, 16'hFFFF);
  endtask

  task automatic t_flag();
    logic [15:0] d;
    bus_write(A_CSR, 16'h0004);
    bus_read(A_CSR, d); check("R7 write 1 keeps flag", d, 16'h0004);
    bus_write(A_CSR, 16'h000C);
    check("R8 irq high", {15'd0, irq}, 16'h0001);
    bus_write(A_CSR, 16'h0008);
    bus_read(A_CSR, d); check("R7 write 0 clears", d, 16'h0008);
    check("R8 irq low after clear", {15'd0, irq}, 16'h0000);
  endtask

  task automatic t_reload();
    logic [15:0] d;
    bus_write(A_CSR, 16'h0000);
    bus_write(A_RLD, 16'd2);
    bus_write(A_CSR, 16'h0413);
    wait_cyc(24);
    bus_read(A_CNT, d); check("R5 reloaded after underflow", d, 16'd2);
    bus_read(A_CSR, d); check("R5 flag on reload underflow", d, 16'h0416);
    bus_write(A_CSR, 16'h0002);
    bus_read(A_CSR, d); check("R9 locked fields kept", d, 16'h0412);
    bus_write(A_RLD, 16'd7);
    bus_read(A_RLD, d); check("R12 reload written while running", d, 16'd7);
  endtask

  task automatic t_halt();
    logic [15:0] a;
    logic [15:0] d;
    bus_write(A_CSR, 16'h0410);
    bus_read(A_CNT, a);
    wait_cyc(20);
    bus_read(A_CNT, d); check("R10 count frozen", d, a);
    bus_write(A_CSR, 16'h0001);
    bus_read(A_CNT, d); check("R3 trigger without enable ignored", d, a);
  endtask

  task automatic t_div32();
    logic [15:0] d;
    bus_write(A_RLD, 16'd3);
    bus_write(A_CSR, 16'h0803);
    wait_cyc(31);
    bus_read(A_CNT, d); check("R2 no step before 32 clocks", d, 16'd3);
    wait_cyc(1);
    bus_read(A_CNT, d); check("R2 step at 32 clocks", d, 16'd2);
  endtask

  task automatic t_reserved();
    logic [15:0] d;
    bus_write(A_CSR, 16'h0000);
    bus_write(A_CSR, 16'h0C03);
    wait_cyc(40);
    bus_read(A_CNT, d); check("R2 reserved select never ticks", d, 16'd3);
  endtask

  task automatic t_collide();
    logic [15:0] d;
    bus_write(A_CSR, 16'h0000);
    bus_write(A_RLD, 16'd1);
    bus_write(A_CSR, 16'h0003);
    wait_cyc(2);
    bus_write(A_CSR, 16'h0002);
    bus_read(A_CSR, d); check("R11 set wins over clear", d, 16'h0006);
    bus_read(A_CNT, d); check("R11 R6 underflow happened", d, 16'hFFFF);
    bus_write(A_CSR, 16'h0002);
    bus_read(A_CSR, d); check("R7 later clear works", d, 16'h0002);
  endtask

  initial begin
    #(8 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    t_reset();
    t_oneshot();
    t_flag();
    t_reload();
    t_halt();
    t_div32();
    t_reserved();
    t_collide();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule